// File: doc/BRIEF.md
# Dual-Tone Keypad Frequency Classifier

This block sits behind the two limiting comparators of a dual-tone keypad receiver. It takes one square wave carrying the low-group tone and one carrying the high-group tone. It measures the period of each wave by counting cycles of the reference clock between rising edges. Each group sums several consecutive periods into one averaged measurement. That measurement is then compared against a fixed tolerance window around each of the four standard frequencies of the group.

A group counts as valid once two back-to-back measurements fall into the same frequency window. A group also becomes absent when its input shows no rising edge for a timeout of a few milliseconds. When both groups are valid at the same time, the block raises a signal-present flag and shows the 4-bit code of the key. A letter-inhibit input stops the 1633 Hz column from ever producing a flag. The analog front end, the filters and any duration guard-timing are left to the surrounding logic.

Top module: `dual_tone_classifier`

## Requirements
- R1: After reset, `sig_present` is 0 and `code_out` is 4'b0000.
- R2: The low-group rows are 697, 770, 852 and 941 Hz, and the high-group columns are 1209, 1336, 1477 and 1633 Hz. The keypad rows are {1,2,3,A}, {4,5,6,B}, {7,8,9,C} and {*,0,#,D}, and each row is read from the lowest column up. While `sig_present` is 1, `code_out` carries the key code. Digits 1..9 give their binary value, 0 gives 4'b1010, * gives 4'b1011, # gives 4'b1100, A gives 4'b1101, B gives 4'b1110, C gives 4'b1111 and D gives 4'b0000.
- R3: A tone whose measured frequency lies within 1.5 % + 2 Hz of a nominal frequency of its group is accepted.
- R4: A tone that deviates by 3.5 % or more from every nominal frequency of its group is rejected, so `sig_present` stays 0.
- R5: A tone in the gap between the accept band and the reject band, such as a 2.5 % deviation, is also rejected.
- R6: `sig_present` is 1 only while both groups hold a valid tone. One group on its own never raises it.
- R7: If a running tone moves out of band, `sig_present` falls as soon as a completed measurement misses. It does not wait for the edge timeout.
- R8: A group that sees no rising edge for TIMEOUT_MS milliseconds of reference clock is treated as absent, and `sig_present` falls.
- R9: While `letter_inhibit` is 1, a pair in the 1633 Hz column (keys A, B, C, D) never raises `sig_present`. Other keys are not affected.
- R10: While `sig_present` is 0, `code_out` holds the code of the last pair that raised it.
- R11: Each measurement is the sum of AVG_N periods. A group only becomes valid on the second of two consecutive measurements that match the same frequency, so no flag appears within the first 2*AVG_N periods after a tone starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; its rate is CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| tone_lo | input | 1 | Hard-limited low-group tone |
| tone_hi | input | 1 | Hard-limited high-group tone |
| letter_inhibit | input | 1 | When 1, suppresses the keys of the 1633 Hz column |
| code_out | output | 4 | Key code of the current pair, or of the last pair held |
| sig_present | output | 1 | Both groups carry a valid standard tone |

## Verification
A wrong period count or a wrong band limit shows up at the ports as a missing or wrong key code. This appears at the end of the second measurement window after the tones start, which is about 2*AVG_N periods of the slower tone. A confirmation register that is stuck or stale lets the flag rise one window early, or keeps it high through a window that missed. The bench catches this by sampling part-way through acquisition and shortly after a tone shifts out of band. An edge-timeout state that never clears keeps the flag high after a tone stops, and this is visible one timeout period later.

// File: rtl/dtmf_pkg.sv
package dtmf_pkg;

  // Nominal frequency in Hz; grp 0 = low group (rows), 1 = high group (columns)
  function automatic int nominal_hz(input bit grp, input int idx);
    int f;
    case ({grp, idx[1:0]})
      3'b000:  f = 697;
      3'b001:  f = 770;
      3'b010:  f = 852;
      3'b011:  f = 941;
      3'b100:  f = 1209;
      3'b101:  f = 1336;
      3'b110:  f = 1477;
      default: f = 1633;
    endcase
    return f;
  endfunction

  // Smallest summed count accepted: the highest allowed frequency is f*1.015 + 2 Hz
  function automatic int band_min(input int clk_hz, input int periods, input int f_hz);
    longint num, fmax_mhz;
    num      = longint'(periods) * longint'(clk_hz) * 64'sd1000;
    fmax_mhz = longint'(f_hz) * 64'sd1015 + 64'sd2000;
    return int'((num + fmax_mhz - 64'sd1) / fmax_mhz);
  endfunction

  // Largest summed count accepted: the lowest allowed frequency is f*0.985 - 2 Hz
  function automatic int band_max(input int clk_hz, input int periods, input int f_hz);
    longint num, fmin_mhz;
    num      = longint'(periods) * longint'(clk_hz) * 64'sd1000;
    fmin_mhz = longint'(f_hz) * 64'sd985 - 64'sd2000;
    return int'(num / fmin_mhz);
  endfunction

  // Key code from row (low-group index) and column (high-group index)
  function automatic logic [3:0] pair_code(input logic [1:0] row, input logic [1:0] col);
    logic [3:0] c;
    if (col == 2'd3)
      c = (row == 2'd3) ? 4'd0 : 4'(4'd13 + {2'b00, row});
    else if (row != 2'd3)
      c = 4'(({2'b00, row} * 4'd3) + {2'b00, col} + 4'd1);
    else
      case (col)
        2'd0:    c = 4'd11;
        2'd1:    c = 4'd10;
        default: c = 4'd12;
      endcase
    return c;
  endfunction

endpackage

// File: rtl/tone_meter.sv
module tone_meter
  import dtmf_pkg::*;
#(
  parameter int CLK_HZ      = 3579545,
  parameter int AVG_N       = 4,
  parameter int TIMEOUT_CYC = 14316,
  parameter bit GRP         = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tone_in,
  output logic       valid,
  output logic [1:0] bin
);
  localparam int CW = $clog2(TIMEOUT_CYC + 1);
  localparam int SW = $clog2(AVG_N * TIMEOUT_CYC + 1);
  localparam int KW = (AVG_N > 1) ? $clog2(AVG_N) : 1;

  logic [2:0]    sync_q;
  logic [CW-1:0] cnt_q;
  logic [SW-1:0] sum_q;
  logic [KW-1:0] nper_q;
  logic          armed_q, prev_hit_q;
  logic [1:0]    prev_bin_q;

  // named internal events
  logic          rise, meas_done, timeout_evt, hit;
  logic [SW-1:0] total;
  logic [3:0]    hit_vec;
  logic [1:0]    bin_now;

  assign rise        = sync_q[1] & ~sync_q[2];
  assign total       = sum_q + SW'(cnt_q);
  assign meas_done   = rise & armed_q & (nper_q == KW'(AVG_N - 1));
  assign timeout_evt = armed_q & ~rise & (cnt_q == CW'(TIMEOUT_CYC));

  for (genvar i = 0; i < 4; i++) begin : g_band
    localparam int LO = band_min(CLK_HZ, AVG_N, nominal_hz(GRP, i));
    localparam int HI = band_max(CLK_HZ, AVG_N, nominal_hz(GRP, i));
    assign hit_vec[i] = (total >= SW'(LO)) && (total <= SW'(HI));
  end

  assign hit = |hit_vec;
  always_comb begin
    bin_now = 2'd0;
    for (int i = 0; i < 4; i++)
      if (hit_vec[i]) bin_now = 2'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q     <= '0;
      cnt_q      <= '0;
      sum_q      <= '0;
      nper_q     <= '0;
      armed_q    <= 1'b0;
      prev_hit_q <= 1'b0;
      prev_bin_q <= 2'd0;
      valid      <= 1'b0;
      bin        <= 2'd0;
    end else begin
      sync_q <= {sync_q[1:0], tone_in};
      if (rise)
        cnt_q <= CW'(1);
      else if (cnt_q != CW'(TIMEOUT_CYC))
        cnt_q <= cnt_q + CW'(1);

      if (timeout_evt) begin
        armed_q    <= 1'b0;
        sum_q      <= '0;
        nper_q     <= '0;
        prev_hit_q <= 1'b0;
        valid      <= 1'b0;
      end else if (rise) begin
        armed_q <= 1'b1;
        if (armed_q) begin
          if (meas_done) begin
            sum_q      <= '0;
            nper_q     <= '0;
            prev_hit_q <= hit;
            prev_bin_q <= bin_now;
            bin        <= bin_now;
            valid      <= hit & prev_hit_q & (bin_now == prev_bin_q);
          end else begin
            sum_q  <= total;
            nper_q <= nper_q + KW'(1);
          end
        end
      end
    end
  end

  // R5 / R4: a measurement outside every band clears the group
  a_r5_miss_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_done && !hit) |=> !valid);
  // R8: edge timeout makes the group absent
  a_r8_timeout_absent: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |=> !valid);
  // R11: validity only appears at the end of a measurement window
  a_r11_valid_on_window: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> $past(meas_done));

endmodule

// File: rtl/dual_tone_classifier.sv
module dual_tone_classifier
  import dtmf_pkg::*;
#(
  parameter int CLK_HZ     = 3579545,
  parameter int AVG_N      = 4,
  parameter int TIMEOUT_MS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tone_lo,
  input  logic       tone_hi,
  input  logic       letter_inhibit,
  output logic [3:0] code_out,
  output logic       sig_present
);
  localparam int TIMEOUT_CYC = (CLK_HZ / 1000) * TIMEOUT_MS;

  logic [1:0] tones;
  logic [1:0] grp_valid;
  logic [1:0] grp_bin [2];
  logic [3:0] code_now, code_q;
  logic       letter_col;

  assign tones = {tone_hi, tone_lo};

  for (genvar g = 0; g < 2; g++) begin : g_grp
    tone_meter #(
      .CLK_HZ(CLK_HZ), .AVG_N(AVG_N), .TIMEOUT_CYC(TIMEOUT_CYC), .GRP(g == 1)
    ) u_meter (
      .clk(clk), .rst_n(rst_n), .tone_in(tones[g]),
      .valid(grp_valid[g]), .bin(grp_bin[g])
    );
  end

  assign letter_col  = (grp_bin[1] == 2'd3);
  assign code_now    = pair_code(grp_bin[0], grp_bin[1]);
  assign sig_present = grp_valid[0] & grp_valid[1] & ~(letter_inhibit & letter_col);
  assign code_out    = sig_present ? code_now : code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= 4'd0;
    else        code_q <= code_out;
  end

  // R10: without a pair, the code output does not move
  a_r10_code_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !sig_present |=> (sig_present || $stable(code_out)));
  // R9: letter keys never show while inhibited
  a_r9_no_letters: assert property (@(posedge clk) disable iff (!rst_n)
    (letter_inhibit && sig_present) |-> !(code_out inside {4'd0, 4'd13, 4'd14, 4'd15}));

endmodule

// File: tb/dual_tone_classifier_test.sv
module dual_tone_classifier_test;
  localparam int CLK_HZ = 200000;
  localparam int IDLE   = 900;
  localparam int SETTLE = 3000;

  logic clk = 1'b0, rst_n = 1'b0, tone_lo = 1'b0, tone_hi = 1'b0, inh = 1'b0;
  logic [3:0] code;
  logic       present;

  dual_tone_classifier #(.CLK_HZ(CLK_HZ), .AVG_N(4), .TIMEOUT_MS(4)) uut (
    .clk(clk), .rst_n(rst_n), .tone_lo(tone_lo), .tone_hi(tone_hi),
    .letter_inhibit(inh), .code_out(code), .sig_present(present));

  always #5 clk = ~clk;

  int lo_per = 0, hi_per = 0;
  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [3:0] last_code = 4'd0;

  always begin
    if (lo_per == 0) begin tone_lo = 1'b0; @(negedge clk); end
    else begin
      int p; p = lo_per;
      tone_lo = 1'b1; repeat (p / 2) @(negedge clk);
      tone_lo = 1'b0; repeat (p - p / 2) @(negedge clk);
    end
  end
  always begin
    if (hi_per == 0) begin tone_hi = 1'b0; @(negedge clk); end
    else begin
      int p; p = hi_per;
      tone_hi = 1'b1; repeat (p / 2) @(negedge clk);
      tone_hi = 1'b0; repeat (p - p / 2) @(negedge clk);
    end
  end

  real row_hz [4] = '{697.0, 770.0, 852.0, 941.0};
  real col_hz [4] = '{1209.0, 1336.0, 1477.0, 1633.0};

  function automatic int per_of(real f);
    return (f <= 0.0) ? 0 : $rtoi(CLK_HZ / f + 0.5);
  endfunction

  function automatic bit in_tol(bit grp, int per, output int idx);
    real f, fn, d;
    idx = 0;
    if (per == 0) return 1'b0;
    f = real'(CLK_HZ) / real'(per);
    for (int i = 0; i < 4; i++) begin
      fn = grp ? col_hz[i] : row_hz[i];
      d  = (f > fn) ? f - fn : fn - f;
      if (d <= 0.015 * fn + 2.0) begin idx = i; return 1'b1; end
    end
    return 1'b0;
  endfunction

  function automatic logic [3:0] exp_code(int row, int col);
    string keys = "123A456B789C*0#D";
    byte   k;
    k = keys[row * 4 + col];
    case (k)
      "0": return 4'd10;
      "*": return 4'd11;
      "#": return 4'd12;
      "A": return 4'd13;
      "B": return 4'd14;
      "C": return 4'd15;
      "D": return 4'd0;
      default: return 4'(k - "0");
    endcase
  endfunction

  typedef struct { bit present; logic [3:0] code; string req; } exp_t;
  exp_t sb_q[$];
  event sample_ev;

  // monitor: pops expectations and compares with the outputs
  initial forever begin
    exp_t it;
    @(sample_ev);
    @(negedge clk);
    it = sb_q.pop_front();
    checks++;
    if (present !== it.present || code !== it.code) begin
      fails++;
      $display("FAIL %s: present=%0b code=%h, expected present=%0b code=%h",
               it.req, present, code, it.present, it.code);
    end
  end

  // driver side: expectation from the current stimulus
  task automatic expect_state(string req, bit force_absent);
    exp_t it;
    int ri, ci;
    bit lok, hok;
    lok = in_tol(1'b0, lo_per, ri);
    hok = in_tol(1'b1, hi_per, ci);
    it.present = !force_absent && lok && hok && !(inh && ci == 3);
    if (it.present) last_code = exp_code(ri, ci);
    it.code = last_code;
    it.req  = req;
    sb_q.push_back(it);
    ->sample_ev;
    repeat (2) @(negedge clk);
  endtask

  task automatic tones(real fl, real fh, int cycles);
    lo_per = per_of(fl);
    hi_per = per_of(fh);
    repeat (cycles) @(negedge clk);
  endtask

  task automatic idle();
    tones(0.0, 0.0, IDLE);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_state("R1 reset state", 1'b0);

    // R11: no flag part-way through acquisition, then key 1
    tones(697.0, 1209.0, 1500);
    expect_state("R11 early window", 1'b1);
    tones(697.0, 1209.0, 1500);
    expect_state("R2 key 1 after confirm", 1'b0);
    idle();
    expect_state("R8 R10 both tones stopped, code held", 1'b0);

    // R2: full keypad
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) begin
        idle();
        tones(row_hz[r], col_hz[c], SETTLE);
        expect_state("R2 keypad pair", 1'b0);
      end

    // R8: one group stops while the other keeps running
    idle();
    tones(770.0, 1336.0, SETTLE);
    expect_state("R2 key 5", 1'b0);
    hi_per = 0;
    repeat (IDLE) @(negedge clk);
    expect_state("R8 high group timeout", 1'b0);

    // R3: inside the accept band
    idle(); tones(770.0 * 1.01, 1336.0 * 0.99, SETTLE);
    expect_state("R3 one percent off", 1'b0);
    idle(); tones(852.0 * 0.986, 1477.0 * 1.014, SETTLE);
    expect_state("R3 near band edge", 1'b0);

    // R4: beyond the reject limit
    idle(); tones(941.0 * 1.04, 1209.0, SETTLE);
    expect_state("R4 low group 4 percent high", 1'b0);
    idle(); tones(697.0, 1633.0 * 0.96, SETTLE);
    expect_state("R4 high group 4 percent low", 1'b0);

    // R5: between accept and reject
    idle(); tones(852.0 * 1.025, 1336.0, SETTLE);
    expect_state("R5 gap deviation", 1'b0);

    // R6: one group alone
    idle(); tones(852.0, 0.0, SETTLE);
    expect_state("R6 low group only", 1'b0);
    idle(); tones(0.0, 1477.0, SETTLE);
    expect_state("R6 high group only", 1'b0);

    // R7: running tone leaves the band, no timeout involved
    idle(); tones(770.0, 1336.0, SETTLE);
    expect_state("R7 setup key 5", 1'b0);
    hi_per = per_of(1336.0 * 1.025);
    repeat (1300) @(negedge clk);
    expect_state("R7 drop on missed window", 1'b0);

    // R9: letter inhibit
    inh = 1'b1;
    idle(); tones(697.0, 1633.0, SETTLE);
    expect_state("R9 key A inhibited", 1'b0);
    idle(); tones(941.0, 1633.0, SETTLE);
    expect_state("R9 key D inhibited", 1'b0);
    idle(); tones(852.0, 1336.0, SETTLE);
    expect_state("R9 key 8 unaffected", 1'b0);
    inh = 1'b0;
    idle(); tones(852.0, 1633.0, SETTLE);
    expect_state("R9 key C released", 1'b0);

    idle();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (all requirements): run still active, expected end before 195000 cycles");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule